// File: doc/BRIEF.md
# Exception Control Register Bank

This block is the small set of system-control registers that sits beside a processor pipeline. It keeps four 32-bit words: the processor status word, the cause of the latest exception, the return address saved at that exception, and the address that caused the latest address fault. Software reaches them through a register-move path. A 5-bit control register number selects the source of a read, which lands in a general register, and the target of a write, which comes from a general register.

Hardware reaches the same registers through an exception-capture port. When the core takes an exception it pulses a valid bit for one cycle and supplies the faulting instruction's PC, a 5-bit exception code and, for address faults, the offending address. On that clock edge the bank saves the PC and puts the code into the cause register. It saves the address only when the code marks an address fault. A capture takes priority over a software write to the same register in the same cycle.

The status and cause registers are writable by software only through per-register bit masks, which are parameters. The saved-PC and fault-address registers take all 32 bits.

Top module: `sysctl_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, the status register takes `STATUS_RESET` (default 0x0040_0000), and the cause, saved-PC and fault-address registers become zero.
- R2: `mv_rd_data` shows the register selected by `mv_rd_sel` in the same cycle, without a clock. The numbers are: fault address 8, status 12, cause 13, saved PC 14.
- R3: Any other `mv_rd_sel` value reads zero. A write to any other number changes none of the four registers.
- R4: A software write to number 12 changes only the status bits set in `STATUS_WMASK` (default 0x0000_FF1F), and the change is visible from the next cycle. All other status bits keep their value.
- R5: A software write to number 13 without a same-cycle exception changes only the cause bits set in `CAUSE_WMASK` (default 0x0000_0300).
- R6: A software write to number 14 or number 8 replaces all 32 bits of that register, unless a same-cycle capture takes that register.
- R7: When `exc_valid` is high at a clock edge, the saved PC becomes `exc_pc` and cause bits [6:2] become `exc_code`. Cause bits outside [6:2] keep their value.
- R8: The fault-address register loads `exc_badaddr` on an exception only when `exc_code` is 4 (fault on load or fetch) or 5 (fault on store). For any other code it is left untouched.
- R9: When a capture and a software write target the same register in the same cycle, the capture wins and the software write is dropped. A software write to the fault-address register still takes effect when the exception code is not an address fault. A status write is never blocked.
- R10: `status_out` always equals the current status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mv_rd_sel | input | 5 | Control register number to read |
| mv_rd_data | output | 32 | Value of the selected register, or zero |
| mv_wr_en | input | 1 | Software write strobe |
| mv_wr_sel | input | 5 | Control register number to write |
| mv_wr_data | input | 32 | Software write data |
| exc_valid | input | 1 | One-cycle exception capture pulse |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_code | input | 5 | Exception code |
| exc_badaddr | input | 32 | Faulting address for address faults |
| status_out | output | 32 | Current status register |

## Verification
The hardest situation to reach is a capture that collides with a software write in the same cycle. It matters most for the fault-address register, where the outcome depends on whether the code marks an address fault. Directed cycles drive each collision on purpose: against the saved PC, against the cause, and against the fault address with both an address-fault code and an ordinary code. The random phase then raises an exception on about one cycle in six, with codes biased toward 4 and 5 and write numbers biased toward the implemented ones, so that many more collisions occur against the bench's own model.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN     = 32;
    localparam int SELW     = 5;
    localparam int CODE_W   = 5;
    localparam int CODE_LSB = 2;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [SELW-1:0]   sel_t;
    typedef logic [CODE_W-1:0] code_t;

    // Register numbers; fixed because software encodes them in its move operations.
    typedef enum logic [SELW-1:0] {
        SEL_BADADDR = 5'd8,
        SEL_STATUS  = 5'd12,
        SEL_CAUSE   = 5'd13,
        SEL_EPC     = 5'd14
    } sel_e;

    localparam code_t CODE_ADDR_LD = 5'd4;
    localparam code_t CODE_ADDR_ST = 5'd5;

    localparam word_t CODE_FIELD_MASK =
        word_t'(((64'd1 << CODE_W) - 64'd1) << CODE_LSB);

    typedef struct packed {
        logic badaddr;
        logic status;
        logic cause;
        logic epc;
    } hit_t;

    typedef struct packed {
        logic  valid;
        word_t pc;
        code_t code;
        word_t badaddr;
    } exc_req_t;

    typedef struct packed {
        logic  en;
        sel_t  sel;
        word_t data;
    } mv_wr_t;

    function automatic logic is_addr_fault(input code_t c);
        return (c == CODE_ADDR_LD) || (c == CODE_ADDR_ST);
    endfunction

    function automatic word_t place_code(input code_t c);
        return word_t'(c) << CODE_LSB;
    endfunction

    function automatic word_t merge_bits(input word_t old_v, input word_t new_v,
                                         input word_t mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  sel_t sel,
    output hit_t hit
);
    always_comb begin
        hit         = '0;
        hit.badaddr = (sel == SEL_BADADDR);
        hit.status  = (sel == SEL_STATUS);
        hit.cause   = (sel == SEL_CAUSE);
        hit.epc     = (sel == SEL_EPC);
    end
endmodule

// File: rtl/sysctl_cell.sv
module sysctl_cell
    import sysctl_pkg::*;
#(
    parameter word_t RESET_VAL = '0,
    parameter word_t SW_MASK   = '1,
    parameter word_t HW_MASK   = '1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sw_we,
    input  word_t sw_data,
    input  logic  hw_we,
    input  word_t hw_data,
    output word_t q
);
    word_t q_r;

    // Hardware capture has priority: a colliding software write is dropped.
    always_ff @(posedge clk) begin
        if (rst)
            q_r <= RESET_VAL;
        else if (hw_we)
            q_r <= merge_bits(q_r, hw_data, HW_MASK);
        else if (sw_we)
            q_r <= merge_bits(q_r, sw_data, SW_MASK);
    end

    assign q = q_r;
endmodule

// File: rtl/sysctl_readmux.sv
module sysctl_readmux
    import sysctl_pkg::*;
(
    input  hit_t  hit,
    input  word_t status_q,
    input  word_t cause_q,
    input  word_t epc_q,
    input  word_t badaddr_q,
    output word_t rd_data
);
    // One-hot AND-OR: unimplemented numbers leave every term at zero.
    always_comb begin
        rd_data = ({XLEN{hit.status}}  & status_q)
                | ({XLEN{hit.cause}}   & cause_q)
                | ({XLEN{hit.epc}}     & epc_q)
                | ({XLEN{hit.badaddr}} & badaddr_q);
    end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter word_t STATUS_RESET = 32'h0040_0000,
    parameter word_t STATUS_WMASK = 32'h0000_FF1F,
    parameter word_t CAUSE_WMASK  = 32'h0000_0300
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  mv_rd_sel,
    output logic [31:0] mv_rd_data,
    input  logic        mv_wr_en,
    input  logic [4:0]  mv_wr_sel,
    input  logic [31:0] mv_wr_data,
    input  logic        exc_valid,
    input  logic [31:0] exc_pc,
    input  logic [4:0]  exc_code,
    input  logic [31:0] exc_badaddr,
    output logic [31:0] status_out
);
    exc_req_t exc;
    mv_wr_t   wr;
    hit_t     wr_hit;
    hit_t     rd_hit;
    word_t    status_q, cause_q, epc_q, badaddr_q;
    logic     addr_cap;

    assign exc      = '{valid: exc_valid, pc: exc_pc, code: exc_code, badaddr: exc_badaddr};
    assign wr       = '{en: mv_wr_en, sel: mv_wr_sel, data: mv_wr_data};
    assign addr_cap = exc.valid && is_addr_fault(exc.code);

    sysctl_decode u_wr_dec (.sel(wr.sel),    .hit(wr_hit));
    sysctl_decode u_rd_dec (.sel(mv_rd_sel), .hit(rd_hit));

    sysctl_cell #(.RESET_VAL(STATUS_RESET), .SW_MASK(STATUS_WMASK), .HW_MASK('0))
    u_status (
        .clk(clk), .rst(rst),
        .sw_we(wr.en && wr_hit.status), .sw_data(wr.data),
        .hw_we(1'b0), .hw_data('0),
        .q(status_q)
    );

    sysctl_cell #(.RESET_VAL('0), .SW_MASK(CAUSE_WMASK), .HW_MASK(CODE_FIELD_MASK))
    u_cause (
        .clk(clk), .rst(rst),
        .sw_we(wr.en && wr_hit.cause), .sw_data(wr.data),
        .hw_we(exc.valid), .hw_data(place_code(exc.code)),
        .q(cause_q)
    );

    sysctl_cell #(.RESET_VAL('0), .SW_MASK('1), .HW_MASK('1))
    u_epc (
        .clk(clk), .rst(rst),
        .sw_we(wr.en && wr_hit.epc), .sw_data(wr.data),
        .hw_we(exc.valid), .hw_data(exc.pc),
        .q(epc_q)
    );

    sysctl_cell #(.RESET_VAL('0), .SW_MASK('1), .HW_MASK('1))
    u_badaddr (
        .clk(clk), .rst(rst),
        .sw_we(wr.en && wr_hit.badaddr), .sw_data(wr.data),
        .hw_we(addr_cap), .hw_data(exc.badaddr),
        .q(badaddr_q)
    );

    sysctl_readmux u_rmux (
        .hit(rd_hit),
        .status_q(status_q), .cause_q(cause_q),
        .epc_q(epc_q), .badaddr_q(badaddr_q),
        .rd_data(mv_rd_data)
    );

    assign status_out = status_q;
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
    import sysctl_pkg::*;
#(
    parameter word_t STATUS_RESET = 32'h0040_0000,
    parameter word_t STATUS_WMASK = 32'h0000_FF1F,
    parameter word_t CAUSE_WMASK  = 32'h0000_0300
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  mv_rd_sel,
    input logic [31:0] mv_rd_data,
    input logic        mv_wr_en,
    input logic [4:0]  mv_wr_sel,
    input logic [31:0] mv_wr_data,
    input logic        exc_valid,
    input logic [31:0] exc_pc,
    input logic [4:0]  exc_code,
    input logic [31:0] exc_badaddr,
    input logic [31:0] status_out,
    input logic [31:0] status_q,
    input logic [31:0] cause_q,
    input logic [31:0] epc_q,
    input logic [31:0] badaddr_q
);
    logic addr_code;
    logic sel_known;
    assign addr_code = (exc_code == 5'd4) || (exc_code == 5'd5);
    assign sel_known = (mv_rd_sel == 5'd8) || (mv_rd_sel == 5'd12) ||
                       (mv_rd_sel == 5'd13) || (mv_rd_sel == 5'd14);

    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (status_q == STATUS_RESET && cause_q == '0 && epc_q == '0 && badaddr_q == '0));

    a_r3_unknown_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !sel_known |-> mv_rd_data == '0);

    a_r4_status_mask: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q ^ $past(status_q)) & ~STATUS_WMASK) == '0);

    a_r5_cause_sw_mask: assert property (@(posedge clk) disable iff (rst)
        (!exc_valid && mv_wr_en && mv_wr_sel == 5'd13) |=>
            cause_q == (($past(cause_q) & ~CAUSE_WMASK) | ($past(mv_wr_data) & CAUSE_WMASK)));

    a_r7_epc_capture: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> epc_q == $past(exc_pc));

    a_r7_code_capture: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> cause_q[6:2] == $past(exc_code));

    a_r8_badaddr_load: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && addr_code) |=> badaddr_q == $past(exc_badaddr));

    a_r8_badaddr_hold: assert property (@(posedge clk) disable iff (rst)
        (!(exc_valid && addr_code) && !(mv_wr_en && mv_wr_sel == 5'd8)) |=> $stable(badaddr_q));

    a_r9_cause_write_dropped: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (cause_q & 32'hFFFF_FF83) == ($past(cause_q) & 32'hFFFF_FF83));

    a_r10_status_mirror: assert property (@(posedge clk) disable iff (rst)
        (mv_rd_sel == 5'd12) |-> mv_rd_data == status_out);
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .STATUS_RESET(STATUS_RESET),
    .STATUS_WMASK(STATUS_WMASK),
    .CAUSE_WMASK(CAUSE_WMASK)
) u_chk (
    .clk(clk), .rst(rst),
    .mv_rd_sel(mv_rd_sel), .mv_rd_data(mv_rd_data),
    .mv_wr_en(mv_wr_en), .mv_wr_sel(mv_wr_sel), .mv_wr_data(mv_wr_data),
    .exc_valid(exc_valid), .exc_pc(exc_pc), .exc_code(exc_code),
    .exc_badaddr(exc_badaddr), .status_out(status_out),
    .status_q(status_q), .cause_q(cause_q), .epc_q(epc_q), .badaddr_q(badaddr_q)
);

// File: tb/tb_sysctl_regbank.sv
`timescale 1ns/1ps
module tb_sysctl_regbank;
    localparam logic [31:0] ST_RST  = 32'h0040_0000;
    localparam logic [31:0] ST_MASK = 32'h0000_FF1F;
    localparam logic [31:0] CA_MASK = 32'h0000_0300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mv_rd_sel = '0;
    logic [31:0] mv_rd_data;
    logic        mv_wr_en = 1'b0;
    logic [4:0]  mv_wr_sel = '0;
    logic [31:0] mv_wr_data = '0;
    logic        exc_valid = 1'b0;
    logic [31:0] exc_pc = '0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_badaddr = '0;
    logic [31:0] status_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] m_status, m_cause, m_epc, m_bad;

    always #2.5 clk = ~clk;

    sysctl_regbank #(.STATUS_RESET(ST_RST), .STATUS_WMASK(ST_MASK), .CAUSE_WMASK(CA_MASK)) dut (
        .clk(clk), .rst(rst), .mv_rd_sel(mv_rd_sel), .mv_rd_data(mv_rd_data),
        .mv_wr_en(mv_wr_en), .mv_wr_sel(mv_wr_sel), .mv_wr_data(mv_wr_data),
        .exc_valid(exc_valid), .exc_pc(exc_pc), .exc_code(exc_code),
        .exc_badaddr(exc_badaddr), .status_out(status_out)
    );

    function automatic logic [31:0] exp_read(input logic [4:0] s);
        case (s)
            5'd8:    return m_bad;
            5'd12:   return m_status;
            5'd13:   return m_cause;
            5'd14:   return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] s);
        case (s)
            5'd8:    return "R8/R6";
            5'd12:   return "R4";
            5'd13:   return "R5/R7";
            5'd14:   return "R6/R7";
            default: return "R3";
        endcase
    endfunction

    // Register behaviour as the requirements state it.
    task automatic model_edge(input logic we, input logic [4:0] ws, input logic [31:0] wd,
                              input logic ev, input logic [31:0] pc, input logic [4:0] code,
                              input logic [31:0] ba);
        logic addr_f;
        addr_f = ev && (code == 5'd4 || code == 5'd5);
        if (we && ws == 5'd12) m_status = (m_status & ~ST_MASK) | (wd & ST_MASK);
        if (ev) begin
            m_epc   = pc;
            m_cause = {m_cause[31:7], code, m_cause[1:0]};
        end else begin
            if (we && ws == 5'd13) m_cause = (m_cause & ~CA_MASK) | (wd & CA_MASK);
            if (we && ws == 5'd14) m_epc = wd;
        end
        if (addr_f) m_bad = ba;
        else if (we && ws == 5'd8) m_bad = wd;
    endtask

    task automatic check_sel(input logic [4:0] s, input string tag);
        mv_rd_sel = s;
        #0.2;
        n_checks++;
        if (mv_rd_data !== exp_read(s)) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", tag, s, mv_rd_data, exp_read(s));
        end
    endtask

    task automatic check_status_out();
        n_checks++;
        if (status_out !== m_status) begin
            n_fail++;
            $display("FAIL R10 status_out actual=%h expected=%h", status_out, m_status);
        end
    endtask

    task automatic check_all(input string tag);
        check_sel(5'd8, tag);
        check_sel(5'd12, tag);
        check_sel(5'd13, tag);
        check_sel(5'd14, tag);
        check_status_out();
    endtask

    task automatic cyc(input logic we, input logic [4:0] ws, input logic [31:0] wd,
                       input logic ev, input logic [31:0] pc, input logic [4:0] code,
                       input logic [31:0] ba);
        @(negedge clk);
        mv_wr_en = we; mv_wr_sel = ws; mv_wr_data = wd;
        exc_valid = ev; exc_pc = pc; exc_code = code; exc_badaddr = ba;
        @(posedge clk);
        model_edge(we, ws, wd, ev, pc, code, ba);
        #0.5;
        mv_wr_en = 1'b0; exc_valid = 1'b0;
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_status = ST_RST; m_cause = '0; m_epc = '0; m_bad = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R6 full-width software writes, R2 same-cycle read view
        cyc(1, 5'd14, 32'hDEAD_BEEF, 0, 0, 0, 0); check_sel(5'd14, "R6");
        cyc(1, 5'd8, 32'h1234_5678, 0, 0, 0, 0);  check_sel(5'd8, "R6");
        check_sel(5'd3, "R2"); check_sel(5'd14, "R2");
        // R4 status mask
        cyc(1, 5'd12, 32'hFFFF_FFFF, 0, 0, 0, 0); check_sel(5'd12, "R4"); check_status_out();
        cyc(1, 5'd12, 32'h0000_0000, 0, 0, 0, 0); check_sel(5'd12, "R4");
        // R5 cause mask
        cyc(1, 5'd13, 32'hFFFF_FFFF, 0, 0, 0, 0); check_sel(5'd13, "R5");
        // R3 unimplemented numbers
        cyc(1, 5'd7, 32'hFFFF_FFFF, 0, 0, 0, 0);
        check_sel(5'd7, "R3"); check_sel(5'd0, "R3"); check_sel(5'd31, "R3"); check_all("R3");
        // R7 capture, R8 no fault address for ordinary code
        cyc(0, 0, 0, 1, 32'h8000_0180, 5'd9, 32'hAAAA_0000); check_all("R7");
        // R8 address faults load fault address
        cyc(0, 0, 0, 1, 32'h0000_4000, 5'd4, 32'h0000_1003); check_all("R8");
        cyc(0, 0, 0, 1, 32'h0000_4010, 5'd5, 32'h0000_2002); check_all("R8");
        // R9 collisions
        cyc(1, 5'd14, 32'h5555_5555, 1, 32'h0000_0200, 5'd12, 0); check_sel(5'd14, "R9");
        cyc(1, 5'd13, 32'hFFFF_FFFF, 1, 32'h0000_0204, 5'd8, 0); check_sel(5'd13, "R9");
        cyc(1, 5'd8, 32'h7777_0000, 1, 32'h0000_0208, 5'd4, 32'h0BAD_0000); check_sel(5'd8, "R9");
        cyc(1, 5'd8, 32'h6666_0000, 1, 32'h0000_020C, 5'd10, 32'h0BAD_1111); check_sel(5'd8, "R9");
        cyc(1, 5'd12, 32'h0000_00A5, 1, 32'h0000_0210, 5'd1, 0); check_sel(5'd12, "R9");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] ws, rs, code;
            logic we, ev;
            int pick;
            pick = $urandom_range(0, 5);
            ws = (pick == 0) ? 5'd8 : (pick == 1) ? 5'd12 : (pick == 2) ? 5'd13 :
                 (pick == 3) ? 5'd14 : 5'($urandom);
            we = ($urandom_range(0, 2) != 0);
            ev = ($urandom_range(0, 5) == 0);
            code = ($urandom_range(0, 1) == 0) ? 5'(4 + $urandom_range(0, 1)) : 5'($urandom);
            cyc(we, ws, $urandom, ev, $urandom, code, $urandom);
            pick = $urandom_range(0, 4);
            rs = (pick == 0) ? 5'd8 : (pick == 1) ? 5'd12 : (pick == 2) ? 5'd13 :
                 (pick == 3) ? 5'd14 : 5'($urandom);
            check_sel(rs, tag_of(rs));
            if (i % 16 == 0) check_status_out();
        end

        // R1 reset again after activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        m_status = ST_RST; m_cause = '0; m_epc = '0; m_bad = '0;
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule